// File: doc/BRIEF.md
# Reloadable Watchdog Countdown Timer

This block is a software-serviced watchdog. A down-counter is loaded from a programmable 10-bit start value whenever software writes a reload register. It then steps down once per slow tick strobe, but only while the power-state input reports the fully-on state. When the count steps from one to zero, the block raises a single-cycle timeout pulse. The counter then rests at zero until the next reload.

Software reaches three registers through a simple write port and a combinational read port:

- A start-value register. Writes of 0 or 1 are refused and the stored value is kept.
- A reload register. The written data is ignored; the write is the reload.
- An 8-bit status byte for progress codes.

The status byte lives in a separate reset domain. It is cleared only by the resume reset, so it survives the ordinary bus reset. Turning real time into the tick strobe, carrying the status byte elsewhere, and acting on a timeout are all left to surrounding logic.

Top module: `reload_watchdog`

## Requirements
- R1: After reset the start value reads 4, the count is 0 and timeout is low. After the resume reset the status byte reads 00h.
- R2: A write to address 1 stores wr_data[9:0] as the start value. A read of address 1 returns the stored value with bits 15:10 as zero.
- R3: A write of 0 or 1 (in bits 9:0) to address 1 leaves the stored start value unchanged.
- R4: A write to address 2 loads the count with the stored start value on the next clock edge. This happens whatever the data and whatever the power state.
- R5: A tick with pwr_state equal to 0 (fully on) and a nonzero count lowers the count by one.
- R6: A tick with pwr_state not equal to 0 leaves the count unchanged.
- R7: When a tick takes the count from 1 to 0, timeout is high for exactly one cycle. The count then stays at 0 through further ticks, with no further pulse, until a reload.
- R8: A reload write and a tick in the same cycle load the start value; the tick is lost.
- R9: A write to address 0 stores wr_data[7:0] as the status byte, which reads back in bits 7:0 of address 0. The bus reset rst_n does not change it.
- R10: rd_data follows rd_addr combinationally, and a read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| rsm_rst_n | input | 1 | Resume reset for the status byte, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 status, 1 start value, 2 reload |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational |
| tick | input | 1 | Single-cycle slow tick strobe |
| pwr_state | input | 2 | Power state; 0 means fully on |
| timeout | output | 1 | One-cycle pulse when the count reaches zero |
| count | output | 10 | Current counter value |

## Verification
The countdown is driven through ticks in each power-state code, which separates a counter that honours the state gate from one that counts regardless. Runs that reach zero, with extra ticks after zero, show whether the timeout pulse is single and whether the counter wraps. Start-value writes of 0, 1, the 10-bit maximum and a value with reserved bits set show whether rejection and masking are correct. A simultaneous reload and tick, and a bus reset with the resume reset held off, test the priority order and the split reset domains.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int INIT_W = 10;
  localparam int STAT_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] A_INIT   = 2'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd2;

  localparam logic [INIT_W-1:0] INIT_RST = 10'd4;
  localparam logic [INIT_W-1:0] INIT_MIN = 10'd2;

  // start values below the minimum are refused
  function automatic logic init_ok(input logic [INIT_W-1:0] v);
    return v >= INIT_MIN;
  endfunction

  // one step down, resting at zero
  function automatic logic [INIT_W-1:0] step_down(input logic [INIT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  // widen a field to bus width with zero fill
  function automatic logic [DATA_W-1:0] zext_init(input logic [INIT_W-1:0] v);
    return {{(DATA_W-INIT_W){1'b0}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] zext_stat(input logic [STAT_W-1:0] v);
    return {{(DATA_W-STAT_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsm_rst_n,
  input  logic              init_wr,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [INIT_W-1:0] init_q,
  output logic [STAT_W-1:0] status_q,
  output logic [DATA_W-1:0] rd_data
);
  logic init_accept;
  assign init_accept = init_wr && init_ok(wr_data[INIT_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           init_q <= INIT_RST;
    else if (init_accept) init_q <= wr_data[INIT_W-1:0];
  end

  // resume-domain register: bus reset does not reach it
  always_ff @(posedge clk or negedge rsm_rst_n) begin
    if (!rsm_rst_n)   status_q <= '0;
    else if (stat_wr) status_q <= wr_data[STAT_W-1:0];
  end

  always_comb begin
    unique case (rd_addr)
      A_STATUS: rd_data = zext_stat(status_q);
      A_INIT:   rd_data = zext_init(init_q);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload_evt,
  input  logic              tick_on,
  input  logic [INIT_W-1:0] init_q,
  output logic [INIT_W-1:0] count,
  output logic              timeout
);
  logic hit_zero;
  assign hit_zero = tick_on && (count == INIT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (reload_evt) begin
        count <= init_q;
      end else if (tick_on) begin
        count   <= step_down(count);
        timeout <= hit_zero;
      end
    end
  end
endmodule

// File: rtl/reload_watchdog.sv
module reload_watchdog
  import wdt_pkg::*;
#(
  parameter logic [1:0] PS_ON = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsm_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick,
  input  logic [1:0]        pwr_state,
  output logic              timeout,
  output logic [INIT_W-1:0] count
);
  // named events for the checker
  logic init_wr, stat_wr, reload_evt, tick_on;
  logic [INIT_W-1:0] init_q;
  logic [STAT_W-1:0] status_q;

  assign init_wr    = wr_en && (wr_addr == A_INIT);
  assign stat_wr    = wr_en && (wr_addr == A_STATUS);
  assign reload_evt = wr_en && (wr_addr == A_RELOAD);
  assign tick_on    = tick && (pwr_state == PS_ON);

  wdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n),
    .init_wr(init_wr), .stat_wr(stat_wr), .wr_data(wr_data),
    .rd_addr(rd_addr), .init_q(init_q), .status_q(status_q),
    .rd_data(rd_data)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .reload_evt(reload_evt),
    .tick_on(tick_on), .init_q(init_q), .count(count),
    .timeout(timeout)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rsm_rst_n,
  input logic              init_wr,
  input logic              stat_wr,
  input logic              reload_evt,
  input logic              tick,
  input logic [1:0]        pwr_state,
  input logic [DATA_W-1:0] wr_data,
  input logic [INIT_W-1:0] init_q,
  input logic [STAT_W-1:0] status_q,
  input logic [INIT_W-1:0] count,
  input logic              timeout
);
  a_r3_bad_init_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (init_wr && wr_data[INIT_W-1:0] < INIT_MIN) |=> $stable(init_q));

  a_r4_reload_loads: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (count == $past(init_q)));

  a_r6_hold_off_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_evt && pwr_state != 2'd0) |=> $stable(count));

  a_r7_pulse_from_one: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (count == '0 && $past(count) == INIT_W'(1) && $past(tick)));

  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_evt && count == '0) |=> (count == '0));

  a_r9_status_kept: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    !stat_wr |=> $stable(status_q));
endmodule

bind reload_watchdog wdt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n), .init_wr(init_wr),
  .stat_wr(stat_wr), .reload_evt(reload_evt), .tick(tick),
  .pwr_state(pwr_state), .wr_data(wr_data), .init_q(init_q),
  .status_q(status_q), .count(count), .timeout(timeout)
);

// File: tb/reload_watchdog_bench.sv
module reload_watchdog_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n, rsm_rst_n, wr_en, tick, timeout;
  logic [1:0]  wr_addr, rd_addr, pwr_state;
  logic [15:0] wr_data, rd_data;
  logic [9:0]  count;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_watchdog u_reload_watchdog (
    .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .tick(tick), .pwr_state(pwr_state),
    .timeout(timeout), .count(count)
  );

  // vector: op[3] data[16] ps[2] exp_count[10] exp_timeout[1]
  // op: 0 idle, 1 write status, 2 write start value, 3 reload, 4 tick, 5 reload+tick
  localparam int NV = 20;
  localparam logic [31:0] VEC [NV] = '{
    {3'd3, 16'h0000, 2'd0, 10'd4,    1'b0}, // R4
    {3'd4, 16'h0000, 2'd0, 10'd3,    1'b0}, // R5
    {3'd4, 16'h0000, 2'd1, 10'd3,    1'b0}, // R6
    {3'd4, 16'h0000, 2'd3, 10'd3,    1'b0}, // R6
    {3'd0, 16'h0000, 2'd0, 10'd3,    1'b0}, // idle
    {3'd4, 16'h0000, 2'd0, 10'd2,    1'b0}, // R5
    {3'd4, 16'h0000, 2'd0, 10'd1,    1'b0}, // R5
    {3'd4, 16'h0000, 2'd0, 10'd0,    1'b1}, // R7
    {3'd4, 16'h0000, 2'd0, 10'd0,    1'b0}, // R7
    {3'd2, 16'h0001, 2'd0, 10'd0,    1'b0}, // R3
    {3'd3, 16'hFFFF, 2'd2, 10'd4,    1'b0}, // R3 R4
    {3'd2, 16'h0000, 2'd0, 10'd4,    1'b0}, // R3
    {3'd3, 16'h0000, 2'd0, 10'd4,    1'b0}, // R3
    {3'd2, 16'hFC02, 2'd0, 10'd4,    1'b0}, // R2
    {3'd5, 16'h0000, 2'd0, 10'd2,    1'b0}, // R8
    {3'd4, 16'h0000, 2'd0, 10'd1,    1'b0}, // R5
    {3'd4, 16'h0000, 2'd0, 10'd0,    1'b1}, // R7
    {3'd2, 16'h03FF, 2'd0, 10'd0,    1'b0}, // R2
    {3'd3, 16'h0000, 2'd0, 10'd1023, 1'b0}, // R4
    {3'd4, 16'h0000, 2'd0, 10'd1022, 1'b0}  // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'h0; tick = 1'b0;
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next fall
  task automatic cycle(input logic [2:0] op, input logic [15:0] d, input logic [1:0] ps);
    pwr_state = ps;
    wr_data   = d;
    case (op)
      3'd1: begin wr_en = 1'b1; wr_addr = 2'd0; end
      3'd2: begin wr_en = 1'b1; wr_addr = 2'd1; end
      3'd3: begin wr_en = 1'b1; wr_addr = 2'd2; end
      3'd4: tick = 1'b1;
      3'd5: begin wr_en = 1'b1; wr_addr = 2'd2; tick = 1'b1; end
      default: ;
    endcase
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rsm_rst_n = 1'b0; pwr_state = 2'd0; rd_addr = 2'd0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1; rsm_rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_addr = 2'd1; #1; check("R1 start value", rd_data, 32'd4);
    rd_addr = 2'd0; #1; check("R1 status", rd_data, 32'd0);
    check("R1 count", count, 32'd0);
    check("R1 timeout", timeout, 32'd0);

    // R1 idle ticks at zero produce no pulse
    cycle(3'd4, 16'h0, 2'd0);
    check("R1 no pulse at zero", timeout, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      cycle(v[31:29], v[28:13], v[12:11]);
      check($sformatf("vec %0d count", i), count, 32'(v[10:1]));
      check($sformatf("vec %0d timeout", i), timeout, 32'(v[0]));
    end

    // R2 R10 readback with masked reserved bits
    rd_addr = 2'd1; #1; check("R2 readback", rd_data, 32'h03FF);
    cycle(3'd2, 16'hFC05, 2'd0);
    rd_addr = 2'd1; #1; check("R2 reserved read zero", rd_data, 32'h0005);
    rd_addr = 2'd3; #1; check("R10 unused address", rd_data, 32'h0);
    rd_addr = 2'd2; #1; check("R10 reload address reads zero", rd_data, 32'h0);

    // R7 pulse lasts one cycle, no wrap
    cycle(3'd2, 16'h0002, 2'd0);
    cycle(3'd3, 16'h0, 2'd0);
    cycle(3'd4, 16'h0, 2'd0);
    cycle(3'd4, 16'h0, 2'd0);
    check("R7 pulse", timeout, 32'd1);
    cycle(3'd0, 16'h0, 2'd0);
    check("R7 pulse ends", timeout, 32'd0);
    check("R7 count rests", count, 32'd0);

    // R9 status byte across bus reset
    cycle(3'd1, 16'hFFA5, 2'd0);
    rd_addr = 2'd0; #1; check("R9 status write", rd_data, 32'h00A5);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_addr = 2'd0; #1; check("R9 status survives bus reset", rd_data, 32'h00A5);
    rd_addr = 2'd1; #1; check("R1 start value after bus reset", rd_data, 32'd4);
    check("R1 count after bus reset", count, 32'd0);
    rsm_rst_n = 1'b0;
    @(negedge clk);
    rsm_rst_n = 1'b1;
    rd_addr = 2'd0; #1; check("R1 status after resume reset", rd_data, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule